// File: doc/BRIEF.md
# Parallel/Serial LCD Panel Bus Controller

This block sits between a host write port and an external LCD panel controller. The host pushes command bytes and data bytes into a 16-entry queue. Each entry carries a register-select flag that marks it as a command or as data. A single bus engine drains the queue onto the panel in one of two strobe styles. The first is an enable strobe with a read/write direction line. The second uses separate active-low read and write strobes. The bus can be 4, 8 or 16 bits wide, or the engine can shift each byte out on a clock/data serial pair.

Each bus cycle has three phases: address setup, strobe active and hold. Each phase has its own programmable length, so one setting suits slow panels and another suits fast ones. When polling is switched on, the engine reads the panel status before every write and waits until the panel reports ready. A maskable interrupt and a DMA request tell the host that the queue has room to refill.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: While reset is held, and after it, the chip select (`lcd_csn`) is high, `lcd_doe` is low, `ser_clk` is low and `fifo_full` is low. The strobes sit at their idle levels: both high in separate-strobe style; enable low and direction high in enable style.
- R2: Separate-strobe style (`cfg_bus6800`=0) with byte width (`cfg_mode`=1): each queue entry gives one write strobe pulse, active low on `lcd_rw_wrn`. The byte is on `lcd_dout[7:0]`. `lcd_rs` equals the entry's flag.
- R3: Enable style (`cfg_bus6800`=1) with byte width: each entry gives one high pulse on `lcd_e_rdn`, with `lcd_rw_wrn` low. The byte is on `lcd_dout[7:0]`, and `lcd_rs` is stable throughout the pulse.
- R4: Nibble width (`cfg_mode`=0): each entry is sent as two write strobes on `lcd_dout[7:4]`, the upper four bits first, and both strobes carry the entry's flag.
- R5: Word width (`cfg_mode`=2): two entries make one write strobe. The first entry forms `lcd_dout[15:8]` and the second forms `lcd_dout[7:0]`. Only the first entry's flag drives `lcd_rs`.
- R6: Serial mode (`cfg_mode`=3): each entry is shifted out most significant bit first on `ser_dout`, valid at each rising edge of `ser_clk`. Chip select stays low and `lcd_rs` holds the flag for all eight bits.
- R7: The setup phase lasts `cfg_setup`+1 cycles, the strobe is active for `cfg_active`+1 cycles and the hold phase lasts `cfg_hold`+1 cycles. Setup is counted from the fall of chip select. Hold is counted from the end of the strobe to the rise of chip select.
- R8: With `cfg_poll`=1 in a parallel mode, each write is preceded by status reads with `lcd_rs` low. Bit 7 of `lcd_din` is sampled in the last active cycle. The write starts only after a read returns that bit as 0.
- R9: The queue holds 16 entries and delivers them in push order. `fifo_full` is high when 16 entries are held. A push while full is dropped.
- R10: `irq` is high exactly when `irq_en`=1 and fewer than 8 entries are queued. `dma_req` follows the same rule with `dma_en`.
- R11: `lcd_doe` is never high while a read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bus6800 | input | 1 | 1: enable strobe with direction line; 0: separate read/write strobes |
| cfg_mode | input | 2 | 0 nibble, 1 byte, 2 word, 3 serial |
| cfg_poll | input | 1 | Poll panel ready status before each write |
| cfg_setup | input | TW | Setup phase length minus one |
| cfg_active | input | TW | Strobe active length minus one |
| cfg_hold | input | TW | Hold phase length minus one |
| irq_en | input | 1 | Interrupt mask (1 = enabled) |
| dma_en | input | 1 | DMA request enable |
| wr_valid | input | 1 | Push an entry this cycle |
| wr_rs | input | 1 | Register-select flag of the pushed entry |
| wr_data | input | 8 | Byte of the pushed entry |
| fifo_full | output | 1 | Queue holds 16 entries |
| irq | output | 1 | Queue below half, masked |
| dma_req | output | 1 | Refill request, enabled by dma_en |
| lcd_csn | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select (0 command/status, 1 data) |
| lcd_rw_wrn | output | 1 | Direction line (enable style) or write strobe, active low |
| lcd_e_rdn | output | 1 | Enable strobe (enable style) or read strobe, active low |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_dout | output | 16 | Data bus toward the panel |
| lcd_din | input | 16 | Data bus from the panel |
| ser_clk | output | 1 | Serial shift clock |
| ser_dout | output | 1 | Serial data |

## Verification
On every cycle, the assertions check the following. An idle chip select always comes with idle strobes and an undriven bus. Reads never coincide with a driven bus and always use a low register select. Every strobe pulse, in every style and mode, lasts exactly the programmed active length. Register select holds steady during a pulse. The interrupt and DMA request respect their enables and stay low when the queue is full. Only the bench scenarios can show what reaches the panel: byte values, nibble and word ordering, serial bit order, setup and hold lengths, the number of busy reads before a write, drop-on-full and delivery order.

// File: rtl/lcdb_pkg.sv
// Shared types for the LCD panel bus controller.
package lcdb_pkg;

    // Bus width / transfer mode selection, encoded as on the cfg_mode port.
    typedef enum logic [1:0] {
        MODE_NIB  = 2'd0,
        MODE_BYTE = 2'd1,
        MODE_WORD = 2'd2,
        MODE_SER  = 2'd3
    } lcdb_mode_e;

    // Phases of one bus strobe cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_HOLD  = 2'd3
    } lcdb_phase_e;

    // One queue entry: register-select flag plus byte.
    typedef struct packed {
        logic       rs;
        logic [7:0] data;
    } lcdb_entry_t;

endpackage

// File: rtl/lcdb_fifo.sv
// Entry queue for the LCD bus controller.
// Holds DEPTH entries. It can pop one or two entries per cycle and exposes the
// two oldest entries. Assumes DEPTH is a power of two, so pointers wrap
// naturally. A push while full is dropped. Pops never exceed the count; the
// engine guarantees this.
module lcdb_fifo
    import lcdb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  lcdb_entry_t       push_entry,
    input  logic [1:0]        pop_n,
    output lcdb_entry_t       head0,
    output lcdb_entry_t       head1,
    output logic [CW-1:0]     count,
    output logic              full
);

    lcdb_entry_t   mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic          push_ok;

    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_ptr + AW'(1)];

    // Storage write, no reset needed for the array.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_ok) - CW'(pop_n);
        end
    end

endmodule

// File: rtl/lcdb_phase_timer.sv
// Down-counter for bus phase lengths.
// A load sets the count to load_val. zero is high once the count reaches 0,
// so a phase entered with a load lasts load_val+1 cycles.
module lcdb_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt;

    assign zero = (cnt == '0);

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

endmodule

// File: rtl/lcdb_engine.sv
// Bus sequencer for the LCD controller.
// Runs setup/active/hold phases for every strobe. Splits bytes into nibbles or
// serial bits, pairs entries in word mode, and inserts status reads when
// polling is on. Assumes the configuration is stable while a transfer is in
// progress. Bus outputs are decoded from registered state only.
module lcdb_engine
    import lcdb_pkg::*;
#(
    parameter int TW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bus6800,
    input  lcdb_mode_e    cfg_mode,
    input  logic          cfg_poll,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_active,
    input  logic [TW-1:0] cfg_hold,
    input  logic [CW-1:0] fifo_count,
    input  lcdb_entry_t   head0,
    input  lcdb_entry_t   head1,
    input  logic          din_busy,
    output logic [1:0]    pop_n,
    output logic          lcd_csn,
    output logic          lcd_rs,
    output logic          lcd_rw_wrn,
    output logic          lcd_e_rdn,
    output logic          lcd_doe,
    output logic [15:0]   lcd_dout,
    output logic          ser_clk,
    output logic          ser_dout
);

    lcdb_phase_e   phase, phase_nx;
    logic          is_rd, is_rd_nx;
    logic [2:0]    beat, beat_nx;
    logic [2:0]    last_beat, last_nx;
    logic [15:0]   shreg, sh_nx;
    logic          cur_rs, rs_nx;
    logic          busy_seen, busy_nx;
    logic          start_wr;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [1:0]    need_n;
    logic          have_data, want_poll;
    logic          in_xfer, in_act, ser_mode;
    logic          unused_rs1;

    assign unused_rs1 = head1.rs;

    lcdb_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign need_n    = (cfg_mode == MODE_WORD) ? 2'd2 : 2'd1;
    assign have_data = (fifo_count >= CW'(need_n));
    assign want_poll = cfg_poll && (cfg_mode != MODE_SER);

    // Next-state decision for phases, beats and write loading.
    always_comb begin
        phase_nx = phase;
        is_rd_nx = is_rd;
        beat_nx  = beat;
        last_nx  = last_beat;
        sh_nx    = shreg;
        rs_nx    = cur_rs;
        busy_nx  = busy_seen;
        tmr_load = 1'b0;
        tmr_val  = cfg_setup;
        pop_n    = 2'd0;
        start_wr = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (have_data) begin
                    tmr_load = 1'b1;
                    phase_nx = PH_SETUP;
                    beat_nx  = 3'd0;
                    if (want_poll) begin
                        is_rd_nx = 1'b1;
                        rs_nx    = 1'b0;
                        last_nx  = (cfg_mode == MODE_NIB) ? 3'd1 : 3'd0;
                    end else begin
                        start_wr = 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = cfg_active;
                    phase_nx = PH_ACT;
                end
            end
            PH_ACT: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = cfg_hold;
                    phase_nx = PH_HOLD;
                    if (is_rd && beat == 3'd0) begin
                        busy_nx = din_busy;
                    end
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    if (beat != last_beat) begin
                        beat_nx  = beat + 3'd1;
                        phase_nx = PH_SETUP;
                        tmr_load = 1'b1;
                    end else if (is_rd) begin
                        beat_nx  = 3'd0;
                        phase_nx = PH_SETUP;
                        tmr_load = 1'b1;
                        start_wr = !busy_seen;
                    end else begin
                        phase_nx = PH_IDLE;
                    end
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
        if (start_wr) begin
            is_rd_nx = 1'b0;
            rs_nx    = head0.rs;
            pop_n    = need_n;
            sh_nx    = (cfg_mode == MODE_WORD) ? {head0.data, head1.data}
                                               : {8'h00, head0.data};
            case (cfg_mode)
                MODE_NIB: last_nx = 3'd1;
                MODE_SER: last_nx = 3'd7;
                default:  last_nx = 3'd0;
            endcase
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            is_rd     <= 1'b0;
            beat      <= 3'd0;
            last_beat <= 3'd0;
            shreg     <= '0;
            cur_rs    <= 1'b0;
            busy_seen <= 1'b0;
        end else begin
            phase     <= phase_nx;
            is_rd     <= is_rd_nx;
            beat      <= beat_nx;
            last_beat <= last_nx;
            shreg     <= sh_nx;
            cur_rs    <= rs_nx;
            busy_seen <= busy_nx;
        end
    end

    assign in_xfer  = (phase != PH_IDLE);
    assign in_act   = (phase == PH_ACT);
    assign ser_mode = (cfg_mode == MODE_SER);

    // Pin decode for chip select, register select and strobes.
    always_comb begin
        lcd_csn = !in_xfer;
        lcd_rs  = in_xfer && cur_rs;
        lcd_doe = in_xfer && !is_rd && !ser_mode;
        if (cfg_bus6800) begin
            lcd_rw_wrn = !in_xfer || is_rd;
            lcd_e_rdn  = in_act && !ser_mode;
        end else begin
            lcd_rw_wrn = !(in_act && !is_rd && !ser_mode);
            lcd_e_rdn  = !(in_act && is_rd && !ser_mode);
        end
        ser_clk  = in_act && ser_mode;
        ser_dout = in_xfer && ser_mode && shreg[3'd7 - beat];
    end

    // Data bus decode per width; zero while not driving.
    always_comb begin
        lcd_dout = 16'h0000;
        if (lcd_doe) begin
            case (cfg_mode)
                MODE_NIB:  lcd_dout = {8'h00, (beat[0] ? shreg[3:0] : shreg[7:4]), 4'h0};
                MODE_WORD: lcd_dout = shreg;
                default:   lcd_dout = {8'h00, shreg[7:0]};
            endcase
        end
    end

endmodule

// File: rtl/lcd_bus_ctrl.sv
// LCD panel bus controller top level.
// Queues command/data bytes and drains them through the bus engine. Raises the
// refill interrupt and DMA request while fewer than LOW_MARK entries are held.
// Assumes the configuration inputs change only while the bus is idle.
module lcd_bus_ctrl
    import lcdb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TW       = 4,
    parameter int LOW_MARK = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bus6800,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_poll,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_active,
    input  logic [TW-1:0] cfg_hold,
    input  logic          irq_en,
    input  logic          dma_en,
    input  logic          wr_valid,
    input  logic          wr_rs,
    input  logic [7:0]    wr_data,
    output logic          fifo_full,
    output logic          irq,
    output logic          dma_req,
    output logic          lcd_csn,
    output logic          lcd_rs,
    output logic          lcd_rw_wrn,
    output logic          lcd_e_rdn,
    output logic          lcd_doe,
    output logic [15:0]   lcd_dout,
    input  logic [15:0]   lcd_din,
    output logic          ser_clk,
    output logic          ser_dout
);

    localparam int CW = $clog2(DEPTH) + 1;

    lcdb_entry_t   push_entry, head0, head1;
    logic [1:0]    pop_n;
    logic [CW-1:0] fifo_count;
    logic          below_mark;
    logic          unused_din;

    assign unused_din = ^{lcd_din[15:8], lcd_din[6:0]};
    assign push_entry = '{rs: wr_rs, data: wr_data};

    lcdb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_valid),
        .push_entry (push_entry),
        .pop_n      (pop_n),
        .head0      (head0),
        .head1      (head1),
        .count      (fifo_count),
        .full       (fifo_full)
    );

    lcdb_engine #(.TW(TW), .CW(CW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_bus6800 (cfg_bus6800),
        .cfg_mode    (lcdb_mode_e'(cfg_mode)),
        .cfg_poll    (cfg_poll),
        .cfg_setup   (cfg_setup),
        .cfg_active  (cfg_active),
        .cfg_hold    (cfg_hold),
        .fifo_count  (fifo_count),
        .head0       (head0),
        .head1       (head1),
        .din_busy    (lcd_din[7]),
        .pop_n       (pop_n),
        .lcd_csn     (lcd_csn),
        .lcd_rs      (lcd_rs),
        .lcd_rw_wrn  (lcd_rw_wrn),
        .lcd_e_rdn   (lcd_e_rdn),
        .lcd_doe     (lcd_doe),
        .lcd_dout    (lcd_dout),
        .ser_clk     (ser_clk),
        .ser_dout    (ser_dout)
    );

    // Refill requests while the queue is below the low mark.
    assign below_mark = (fifo_count < CW'(LOW_MARK));
    assign irq        = irq_en && below_mark;
    assign dma_req    = dma_en && below_mark;

endmodule

// File: rtl/lcd_bus_ctrl_chk.sv
// Port-level protocol checker for lcd_bus_ctrl, attached by bind.
// Measures strobe widths with its own counter and checks idle, read and
// request rules on every cycle.
module lcd_bus_ctrl_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_bus6800,
    input logic [1:0]    cfg_mode,
    input logic [TW-1:0] cfg_active,
    input logic          irq_en,
    input logic          dma_en,
    input logic          fifo_full,
    input logic          irq,
    input logic          dma_req,
    input logic          lcd_csn,
    input logic          lcd_rs,
    input logic          lcd_rw_wrn,
    input logic          lcd_e_rdn,
    input logic          lcd_doe,
    input logic          ser_clk
);

    logic       strb;
    logic       rd_strb;
    logic [7:0] wcnt;

    // Any strobe pulse of the selected style.
    always_comb begin
        if (cfg_mode == 2'd3) begin
            strb = ser_clk;
        end else if (cfg_bus6800) begin
            strb = lcd_e_rdn;
        end else begin
            strb = !lcd_rw_wrn || !lcd_e_rdn;
        end
        rd_strb = cfg_bus6800 ? (lcd_e_rdn && lcd_rw_wrn) : !lcd_e_rdn;
    end

    // Length of the current strobe pulse in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 8'd0;
        end else begin
            wcnt <= strb ? wcnt + 8'd1 : 8'd0;
        end
    end

    a_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strb) && !strb) |-> (wcnt == 8'(cfg_active) + 8'd1));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_csn |-> (!ser_clk && !lcd_doe &&
                     (cfg_bus6800 ? (!lcd_e_rdn && lcd_rw_wrn) : (lcd_e_rdn && lcd_rw_wrn))));

    a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strb |-> !lcd_doe);

    a_r8_status_rs_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strb |-> !lcd_rs);

    a_r3_rs_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && $past(strb)) |-> $stable(lcd_rs));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r10_dma_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    a_r10_full_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (!irq && !dma_req));

endmodule

bind lcd_bus_ctrl lcd_bus_ctrl_chk #(.TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_bus6800 (cfg_bus6800),
    .cfg_mode    (cfg_mode),
    .cfg_active  (cfg_active),
    .irq_en      (irq_en),
    .dma_en      (dma_en),
    .fifo_full   (fifo_full),
    .irq         (irq),
    .dma_req     (dma_req),
    .lcd_csn     (lcd_csn),
    .lcd_rs      (lcd_rs),
    .lcd_rw_wrn  (lcd_rw_wrn),
    .lcd_e_rdn   (lcd_e_rdn),
    .lcd_doe     (lcd_doe),
    .ser_clk     (ser_clk)
);

// File: tb/lcd_bus_ctrl_test.sv
// Self-checking bench for lcd_bus_ctrl: a panel model decodes the bus
// independently, a vector table covers styles and widths, directed tests cover
// timing, busy polling, queue limits and requests.
module lcd_bus_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {style(1), mode(2), rs(1), data(16)}
    localparam logic [19:0] VEC [NVEC] = '{
        20'h300A5, 20'h2003C, 20'hB005A, 20'h100C7, 20'h80091,
        20'h5BEEF, 20'hC1234, 20'h700B2, 20'hE004D
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus6800 = 1'b0;
    logic [1:0]  cfg_mode = 2'd1;
    logic        cfg_poll = 1'b0;
    logic [3:0]  cfg_setup = 4'd1, cfg_active = 4'd2, cfg_hold = 4'd1;
    logic        irq_en = 1'b1, dma_en = 1'b0;
    logic        wr_valid = 1'b0, wr_rs = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        fifo_full, irq, dma_req, lcd_csn, lcd_rs, lcd_rw_wrn, lcd_e_rdn, lcd_doe;
    logic [15:0] lcd_dout;
    logic [15:0] lcd_din;
    logic        ser_clk, ser_dout;

    // Panel model state (monitor-owned) and controls (stimulus-owned).
    int          rd_count = 0;
    int          busy_until = 0;
    logic        busy_hold = 1'b0;
    logic [15:0] rec_val [64];
    logic        rec_rs [64];
    int          rec_rdc [64];
    int          rec_n = 0;
    logic        doe_bad = 1'b0, rd_rs_bad = 1'b0;
    int          last_setup = 0, last_act = 0, last_hold = 0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    assign lcd_din = {8'h00, (busy_hold || (rd_count < busy_until)), 7'h00};

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_bus6800(cfg_bus6800), .cfg_mode(cfg_mode),
        .cfg_poll(cfg_poll), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_hold(cfg_hold), .irq_en(irq_en), .dma_en(dma_en), .wr_valid(wr_valid),
        .wr_rs(wr_rs), .wr_data(wr_data), .fifo_full(fifo_full), .irq(irq),
        .dma_req(dma_req), .lcd_csn(lcd_csn), .lcd_rs(lcd_rs), .lcd_rw_wrn(lcd_rw_wrn),
        .lcd_e_rdn(lcd_e_rdn), .lcd_doe(lcd_doe), .lcd_dout(lcd_dout), .lcd_din(lcd_din),
        .ser_clk(ser_clk), .ser_dout(ser_dout)
    );

    // Panel-side monitor: decodes strobes, records writes, counts reads and phase lengths.
    logic        p_wr = 1'b0, p_rd = 1'b0, p_rs = 1'b0, p_sclk = 1'b0, p_csn = 1'b1;
    logic [15:0] p_dout = 16'h0;
    logic [7:0]  sbuf = 8'h0;
    int          sbits = 0, act_cnt = 0, setup_cnt = 0, hold_cnt = 0;
    logic        seen_strb = 1'b0;
    always @(negedge clk) begin
        logic wr_now, rd_now, st_now;
        wr_now = (cfg_mode != 2'd3) && (cfg_bus6800 ? (lcd_e_rdn && !lcd_rw_wrn) : !lcd_rw_wrn);
        rd_now = (cfg_mode != 2'd3) && (cfg_bus6800 ? (lcd_e_rdn && lcd_rw_wrn) : !lcd_e_rdn);
        st_now = wr_now || rd_now || ser_clk;
        if (p_wr && !wr_now && rec_n < 64) begin
            rec_val[rec_n] = p_dout; rec_rs[rec_n] = p_rs; rec_rdc[rec_n] = rd_count;
            rec_n = rec_n + 1;
        end
        if (p_rd && !rd_now) begin
            rd_count = rd_count + 1;
            if (p_rs) rd_rs_bad = 1'b1;
        end
        if (rd_now && lcd_doe) doe_bad = 1'b1;
        if (lcd_csn) sbits = 0;
        else if (ser_clk && !p_sclk) begin
            sbuf = {sbuf[6:0], ser_dout};
            sbits = sbits + 1;
            if (sbits == 8 && rec_n < 64) begin
                rec_val[rec_n] = {8'h00, sbuf}; rec_rs[rec_n] = lcd_rs; rec_rdc[rec_n] = rd_count;
                rec_n = rec_n + 1; sbits = 0;
            end
        end
        if (st_now) act_cnt = act_cnt + 1;
        else if (act_cnt != 0) begin last_act = act_cnt; act_cnt = 0; end
        if (lcd_csn) begin
            if (!p_csn) last_hold = hold_cnt;
            setup_cnt = 0; hold_cnt = 0; seen_strb = 1'b0;
        end else if (st_now) begin
            if (!seen_strb) last_setup = setup_cnt;
            seen_strb = 1'b1; hold_cnt = 0;
        end else if (seen_strb) hold_cnt = hold_cnt + 1;
        else setup_cnt = setup_cnt + 1;
        p_wr = wr_now; p_rd = rd_now; p_rs = lcd_rs; p_dout = lcd_dout;
        p_sclk = ser_clk; p_csn = lcd_csn;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic rs, input logic [7:0] d);
        wr_rs = rs; wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int hi = 0;
        int lim = 0;
        repeat (2) @(negedge clk);
        while (hi < 6 && lim < 5000) begin
            @(negedge clk);
            hi = lcd_csn ? hi + 1 : 0;
            lim = lim + 1;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
            $finish;
        end
    end

    initial begin
        logic [19:0] v;
        logic [15:0] d;
        int base, rd0;
        string tag;
        repeat (3) @(negedge clk);
        // R1: idle state during and after reset; R10 masking at empty queue
        check(lcd_csn && !lcd_doe && !ser_clk && !fifo_full, "R1", "reset csn/doe/sclk/full",
              {lcd_csn, lcd_doe, ser_clk, fifo_full}, 4'b1000);
        check(lcd_rw_wrn && lcd_e_rdn, "R1", "reset strobes", {lcd_rw_wrn, lcd_e_rdn}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(lcd_csn && lcd_rw_wrn && lcd_e_rdn && !lcd_doe, "R1", "after reset idle",
              {lcd_csn, lcd_rw_wrn, lcd_e_rdn, lcd_doe}, 4'b1110);
        check(irq && !dma_req, "R10", "empty queue irq/dma", {irq, dma_req}, 2'b10);

        // Vector table: styles and widths
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            cfg_bus6800 = v[19]; cfg_mode = v[18:17]; d = v[15:0];
            @(negedge clk);
            base = rec_n;
            if (cfg_mode == 2'd2) begin
                push(v[16], d[15:8]);
                push(!v[16], d[7:0]);
            end else begin
                push(v[16], d[7:0]);
            end
            wait_idle();
            case (cfg_mode)
                2'd0: tag = "R4";
                2'd2: tag = "R5";
                2'd3: tag = "R6";
                default: tag = cfg_bus6800 ? "R3" : "R2";
            endcase
            if (cfg_mode == 2'd0) begin
                check(rec_n == base + 2 && rec_val[base][7:4] == d[7:4] &&
                      rec_val[base+1][7:4] == d[3:0] && rec_rs[base] == v[16] &&
                      rec_rs[base+1] == v[16], tag, "nibble pair",
                      {rec_rs[base], rec_val[base][7:4], rec_val[base+1][7:4]}, {v[16], d[7:0]});
            end else begin
                logic [15:0] exp;
                exp = (cfg_mode == 2'd2) ? d : {8'h00, d[7:0]};
                check(rec_n == base + 1 && rec_val[base] == exp && rec_rs[base] == v[16],
                      tag, "transfer", {rec_rs[base], rec_val[base]}, {v[16], exp});
            end
        end

        // R7: programmed phase lengths, separate-strobe style
        cfg_bus6800 = 1'b0; cfg_mode = 2'd1; cfg_setup = 4'd2; cfg_active = 4'd3; cfg_hold = 4'd1;
        @(negedge clk);
        push(1'b1, 8'h77);
        wait_idle();
        check(last_setup == 3, "R7", "setup length", last_setup, 3);
        check(last_act == 4, "R7", "strobe length", last_act, 4);
        check(last_hold == 2, "R7", "hold length", last_hold, 2);
        // R7: shortest strobe, enable style
        cfg_bus6800 = 1'b1; cfg_setup = 4'd0; cfg_active = 4'd0; cfg_hold = 4'd0;
        @(negedge clk);
        push(1'b0, 8'h11);
        wait_idle();
        check(last_act == 1, "R7", "one-cycle enable", last_act, 1);

        // R8: busy polling holds the write until ready
        cfg_bus6800 = 1'b0; cfg_poll = 1'b1; cfg_active = 4'd1;
        rd0 = rd_count; busy_until = rd_count + 3;
        @(negedge clk);
        base = rec_n;
        push(1'b1, 8'h6E);
        wait_idle();
        check(rd_count - rd0 == 4, "R8", "status reads", rd_count - rd0, 4);
        check(rec_n == base + 1 && rec_val[base] == 16'h006E, "R8", "write after ready",
              rec_val[base], 16'h006E);
        check(rec_rdc[base] == rd0 + 4, "R8", "write follows last read", rec_rdc[base], rd0 + 4);
        check(!rd_rs_bad, "R8", "rs low on reads", rd_rs_bad, 0);
        check(!doe_bad, "R11", "bus undriven on reads", doe_bad, 0);

        // R9/R10: fill while the panel reports busy
        busy_hold = 1'b1; dma_en = 1'b1;
        @(negedge clk);
        base = rec_n;
        for (int k = 0; k < 7; k++) push(1'b1, 8'(k));
        check(irq && dma_req, "R10", "7 entries requests", {irq, dma_req}, 2'b11);
        push(1'b1, 8'd7);
        check(!irq && !dma_req, "R10", "8 entries no request", {irq, dma_req}, 2'b00);
        for (int k = 8; k < 16; k++) push(1'b1, 8'(k));
        check(fifo_full, "R9", "full at 16", fifo_full, 1);
        push(1'b0, 8'hFF);
        check(fifo_full, "R9", "still full after drop", fifo_full, 1);
        busy_hold = 1'b0;
        wait_idle();
        begin
            bit ord_ok;
            ord_ok = (rec_n == base + 16);
            for (int k = 0; k < 16; k++)
                if (rec_val[base+k] != 16'(k) || !rec_rs[base+k]) ord_ok = 1'b0;
            check(ord_ok, "R9", "16 in order, overflow dropped", rec_n - base, 16);
        end
        check(!fifo_full && irq, "R10", "drained requests", {fifo_full, irq}, 2'b01);
        irq_en = 1'b0;
        @(negedge clk);
        check(!irq && dma_req, "R10", "irq masked", {irq, dma_req}, 2'b01);
        check(!doe_bad, "R11", "no drive during reads overall", doe_bad, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule